// File: doc/BRIEF.md
# Read Output Pipeline with Selectable Latency and Deselect Depth

This block sits between the array of a synchronous memory and its data bus. It decides in which clock cycle read data appears on the bus and in which cycles the bus is driven. Each clock edge captures a command into an input stage. A read then reads the array during the following cycle. The environment supplies the raw array data for that cycle on `arr_rdata`.

Two static configuration inputs shape the timing. `cfg_pipe` chooses between two output paths. With `cfg_pipe` low (flow-through), array data goes straight to the bus. With `cfg_pipe` high (pipelined), array data passes through a rising-edge output register, which adds one cycle. So the first beat arrives in cycle 2 (flow-through) or cycle 3 (pipelined), counting the cycle that presents the command as cycle 1, and each following burst beat arrives one cycle later. `cfg_dcd` chooses how far a deselect travels down the pipeline before the bus is released. In dual mode, a deselect releases the bus in the same cycle a read would have started driving it. In single mode, it releases the bus one stage earlier. The asynchronous active-low `oe_n` masks bus drive at any moment.

Top module: `rdout_pipe`

## Requirements
- R1: While `rst_n` is low, every pipeline stage holds deselect: `dq_oe` is 0 and, in pipelined mode, `dq_out` is 0.
- R2: Flow-through (`cfg_pipe`=0), with `oe_n` low. Suppose a read (`cmd_i`=2'b01) is captured at edge E. In the cycle after E, `dq_oe` is 1 and `dq_out` equals `arr_rdata` of that same cycle.
- R3: Pipelined (`cfg_pipe`=1), with `oe_n` low. Suppose a read is captured at edge E. In the cycle after edge E+1, `dq_out` equals the `arr_rdata` that was present in the cycle after E, and `dq_oe` is 1. The one exception is single-deselect mode with a deselect captured at E+1 (see R6).
- R4: Reads captured on consecutive edges give a new data word every cycle, and `dq_oe` stays 1 without a gap.
- R5: Pipelined dual-deselect mode (`cfg_dcd`=1). Suppose a read is captured at E and a deselect (`cmd_i`=2'b00) at E+1. `dq_oe` stays 1 through the cycle after E+1 and falls after E+2.
- R6: Pipelined single-deselect mode (`cfg_dcd`=0). Suppose a read is captured at E and a deselect at E+1. `dq_oe` is 0 in the cycle right after E+1.
- R7: Flow-through mode, in either deselect mode. A deselect captured at edge E makes `dq_oe` 0 in the cycle after E.
- R8: A write (`cmd_i`=2'b10) never drives the bus. In the cycle where its output stage falls, `dq_oe` is 0: the cycle after capture in flow-through mode, and the cycle after the next edge in pipelined mode.
- R9: `oe_n` high forces `dq_oe` to 0 within the same cycle, without waiting for a clock edge. Lowering `oe_n` again restores the pipelined value at once.
- R10: Pipelined mode. When the stage feeding the output register holds no read, the register keeps its value, so `dq_out` does not change.
- R11: The spare code `cmd_i`=2'b11 behaves exactly like a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pipe | input | 1 | Static: 1 selects the registered output, 0 selects flow-through |
| cfg_dcd | input | 1 | Static: 1 selects dual-cycle deselect, 0 selects single-cycle |
| oe_n | input | 1 | Asynchronous active-low output enable |
| cmd_i | input | 2 | Command: 00 deselect, 01 read, 10 write, 11 deselect |
| arr_rdata | input | DATA_W | Raw array data for the read in the capture stage |
| dq_out | output | DATA_W | Data presented to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench runs the same command mix in all four combinations of the two mode inputs. This catches a design whose deselect depth ignores the latency mode: for example, one that releases the bus early in flow-through mode, or late in single-deselect pipelined mode, so the bus would fight or float for one cycle. Read-then-deselect, read-then-write and write-then-read pairs test the enable at the edges of bursts. A missing write mask would show up as a driven bus during a write beat. An output register that loads on every edge would show up as changing data during idle cycles. Short `oe_n` pulses in the middle of a cycle confirm that a design gating the enable through a flop is caught.

// File: rtl/rdout_pkg.sv
package rdout_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_SPARE = 2'd3
  } op_e;

  // Map a raw command to an operation; the spare code folds into deselect.
  function automatic op_e op_decode(input logic [1:0] raw);
    case (raw)
      2'd1:    return OP_READ;
      2'd2:    return OP_WRITE;
      default: return OP_IDLE;
    endcase
  endfunction

  function automatic logic op_drives(input op_e op);
    return op == OP_READ;
  endfunction

  function automatic logic op_releases(input op_e op);
    return op == OP_IDLE;
  endfunction

  // Selected state of the bus for one cycle.
  // cap  : operation in the capture stage (array read this cycle)
  // held : operation one stage further on (output register stage)
  function automatic logic drive_window(input logic pipe, input logic dcd,
                                        input op_e cap, input op_e held);
    if (!pipe) return op_drives(cap);
    if (dcd)   return op_drives(held);
    return op_drives(held) && !op_releases(cap);
  endfunction

endpackage

// File: rtl/rdout_op_pipe.sv
module rdout_op_pipe
  import rdout_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  op_e  op_in,
  output op_e  op_stage [DEPTH]
);

  op_e op_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_q[g] <= OP_IDLE;
        else        op_q[g] <= op_in;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_q[g] <= OP_IDLE;
        else        op_q[g] <= op_q[g-1];
      end
    end
    assign op_stage[g] = op_q[g];
  end

endmodule

// File: rtl/rdout_data_path.sv
module rdout_data_path #(
  parameter int unsigned DATA_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pipe,
  input  logic              load,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dq
);

  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    out_q <= '0;
    else if (load) out_q <= arr_rdata;
  end

  assign dq = cfg_pipe ? out_q : arr_rdata;

endmodule

// File: rtl/rdout_drive_ctl.sv
module rdout_drive_ctl
  import rdout_pkg::*;
(
  input  logic cfg_pipe,
  input  logic cfg_dcd,
  input  logic oe_n,
  input  op_e  op_cap,
  input  op_e  op_held,
  output logic selected,
  output logic bus_oe
);

  assign selected = drive_window(cfg_pipe, cfg_dcd, op_cap, op_held);
  assign bus_oe   = selected & ~oe_n;

endmodule

// File: rtl/rdout_pipe.sv
module rdout_pipe
  import rdout_pkg::*;
#(
  parameter int unsigned DATA_W = 72
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pipe,
  input  logic              cfg_dcd,
  input  logic              oe_n,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int unsigned CAP_STG  = 0;
  localparam int unsigned HELD_STG = CAP_STG + 1;
  localparam int unsigned STAGES   = HELD_STG + 1;

  op_e op_in;
  op_e op_stage [STAGES];
  op_e op_cap;
  op_e op_held;
  logic cap_is_read;
  logic bus_selected;

  assign op_in       = op_decode(cmd_i);
  assign op_cap      = op_stage[CAP_STG];
  assign op_held     = op_stage[HELD_STG];
  assign cap_is_read = op_drives(op_cap);

  rdout_op_pipe #(.DEPTH(STAGES)) u_ops (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_in    (op_in),
    .op_stage (op_stage)
  );

  rdout_data_path #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pipe  (cfg_pipe),
    .load      (cap_is_read),
    .arr_rdata (arr_rdata),
    .dq        (dq_out)
  );

  rdout_drive_ctl u_drive (
    .cfg_pipe (cfg_pipe),
    .cfg_dcd  (cfg_dcd),
    .oe_n     (oe_n),
    .op_cap   (op_cap),
    .op_held  (op_held),
    .selected (bus_selected),
    .bus_oe   (dq_oe)
  );

endmodule

// File: rtl/rdout_pipe_chk.sv
module rdout_pipe_chk #(
  parameter int unsigned DATA_W = 72
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_pipe,
  input logic              cfg_dcd,
  input logic              oe_n,
  input logic [1:0]        cmd_i,
  input logic [DATA_W-1:0] arr_rdata,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  logic ok1, ok2;
  assign ok1 = since_rst >= 2'd1;
  assign ok2 = since_rst >= 2'd2;

  always @(negedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!dq_oe); // R1
    end
  end

  AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe); // R9

  AST_FT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ok1 && !cfg_pipe && !oe_n && $past(cmd_i) == 2'b01) |-> (dq_oe && dq_out == arr_rdata)); // R2

  AST_PL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && cfg_pipe && $past(cmd_i, 2) == 2'b01) |-> (dq_out == $past(arr_rdata))); // R3

  AST_DCD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && cfg_pipe && cfg_dcd && !oe_n && $past(cmd_i, 2) == 2'b01) |-> dq_oe); // R5

  AST_SCD_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ok1 && cfg_pipe && !cfg_dcd && ($past(cmd_i) == 2'b00 || $past(cmd_i) == 2'b11)) |-> !dq_oe); // R6

  AST_FT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (ok1 && !cfg_pipe && $past(cmd_i) != 2'b01) |-> !dq_oe); // R7

  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && cfg_pipe && $past(cmd_i, 2) == 2'b10) |-> !dq_oe); // R8

  AST_PL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ok2 && cfg_pipe && $past(cmd_i, 2) != 2'b01) |-> $stable(dq_out)); // R10

endmodule

bind rdout_pipe rdout_pipe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_pipe  (cfg_pipe),
  .cfg_dcd   (cfg_dcd),
  .oe_n      (oe_n),
  .cmd_i     (cmd_i),
  .arr_rdata (arr_rdata),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe)
);

// File: tb/rdout_pipe_test.sv
`timescale 1ns/1ps
module rdout_pipe_test;

  localparam int unsigned DW = 72;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_pipe = 1'b0;
  logic          cfg_dcd  = 1'b0;
  logic          oe_n     = 1'b0;
  logic [1:0]    cmd_i    = 2'b00;
  logic [DW-1:0] arr_rdata = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct {
    int            at;
    logic          oe;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t sb[$];

  logic [1:0]    last_cmd;
  logic [DW-1:0] last_pl;

  always #4 clk = ~clk;

  rdout_pipe #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_pipe(cfg_pipe), .cfg_dcd(cfg_dcd),
    .oe_n(oe_n), .cmd_i(cmd_i), .arr_rdata(arr_rdata),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] arr_word(input int c);
    logic [7:0] b;
    b = 8'(c * 37 + 5);
    return {(DW/8){b}} ^ DW'(c);
  endfunction

  // Array data for cycle c appears shortly after edge c.
  always @(posedge clk) begin
    #0.5;
    cyc = cyc + 1;
    arr_rdata = arr_word(cyc);
  end

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (pipe=%0b dcd=%0b cyc=%0d)",
               tag, act, exp, cfg_pipe, cfg_dcd, cyc);
    end
  endtask

  // Monitor: pops the expectation for the current cycle.
  always @(negedge clk) begin
    if (rst_n && sb.size() != 0 && sb[0].at == cyc) begin
      exp_t it;
      it = sb.pop_front();
      check(dq_oe === it.oe, {it.tag, " dq_oe"}, DW'(dq_oe), DW'(it.oe));
      check(dq_out === it.data, {it.tag, " dq_out"}, dq_out, it.data);
    end
  end

  function automatic bit is_rd(input logic [1:0] c); return c == 2'b01; endfunction
  function automatic bit is_off(input logic [1:0] c); return c == 2'b00 || c == 2'b11; endfunction

  // Driver: issues one command and pushes what the bus must show next cycle.
  task automatic issue(input logic [1:0] c);
    exp_t it;
    int now;
    @(posedge clk);
    #1;
    cmd_i = c;
    now   = cyc;
    it.at = now + 1;
    if (!cfg_pipe) begin
      it.oe   = is_rd(c);
      it.data = arr_word(now + 1);
      if (c == 2'b10)      it.tag = "R8";
      else if (c == 2'b11) it.tag = "R11";
      else if (is_rd(c))   it.tag = is_rd(last_cmd) ? "R4" : "R2";
      else                 it.tag = "R7";
    end else begin
      it.oe   = is_rd(last_cmd) && (cfg_dcd || !is_off(c));
      it.data = is_rd(last_cmd) ? arr_word(now) : last_pl;
      if (is_rd(last_cmd)) last_pl = arr_word(now);
      if (last_cmd == 2'b10 || c == 2'b10)  it.tag = "R8";
      else if (c == 2'b11)                  it.tag = "R11";
      else if (is_rd(last_cmd) && is_off(c)) it.tag = cfg_dcd ? "R5" : "R6";
      else if (is_rd(last_cmd) && is_rd(c))  it.tag = "R4";
      else if (is_rd(last_cmd))              it.tag = "R3";
      else                                   it.tag = "R10";
    end
    last_cmd = c;
    sb.push_back(it);
  endtask

  // Mid-cycle output-enable pulse while the bus should be driven.
  task automatic oe_pulse();
    #0.5;
    oe_n = 1'b1;
    #0.5;
    check(dq_oe === 1'b0, "R9 masked", DW'(dq_oe), DW'(0));
    oe_n = 1'b0;
    #0.5;
    check(dq_oe === 1'b1, "R9 restored", DW'(dq_oe), DW'(1));
  endtask

  task automatic run_mode(input logic p, input logic d);
    @(posedge clk);
    #1;
    rst_n    = 1'b0;
    cmd_i    = 2'b00;
    cfg_pipe = p;
    cfg_dcd  = d;
    sb.delete();
    last_cmd = 2'b00;
    last_pl  = '0;
    repeat (2) @(negedge clk);
    check(dq_oe === 1'b0, "R1 oe in reset", DW'(dq_oe), DW'(0));
    if (p) check(dq_out === '0, "R1 data in reset", dq_out, '0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    issue(2'b01); issue(2'b01); issue(2'b01);
    oe_pulse();
    issue(2'b01);
    issue(2'b00);
    issue(2'b01); issue(2'b10); issue(2'b01);
    issue(2'b11);
    issue(2'b00); issue(2'b00);
    issue(2'b01); issue(2'b01);
    issue(2'b10); issue(2'b10);
    issue(2'b01);
    issue(2'b00); issue(2'b00); issue(2'b00);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    run_mode(1'b0, 1'b0);
    run_mode(1'b0, 1'b1);
    run_mode(1'b1, 1'b0);
    run_mode(1'b1, 1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule